// File: doc/BRIEF.md
# Page-Mode ROM Read Sequencer

This block drives the control, address and data-capture side of an external asynchronous ROM that supports page-mode reads. On a burst read it pulls chip select and the read strobe low once. It keeps both low for every beat of the burst and moves only the address from beat to beat. The first beat of a transaction waits for a long programmable count and can be stretched further by an external wait input. Each later beat waits for a separate short count, and the external wait input does not affect it.

A request carries a start address, a beat count, a write flag and a burst flag. It is taken while `req_ready` is high. Two configuration fields set the first-beat wait and the later-beat wait. Single reads and all writes fall back to one normal access. The data for each read beat is captured into `rdata`, and `rdata_valid` is raised for one clock with it.

Top module: `pgrom_rd_ctrl`

## Requirements
- R1: During a burst read, `cs_n` and `rd_n` stay low without a break from the first cycle of the first beat to the last cycle of the last beat.
- R2: Without external wait, the first beat of any transaction lasts `cfg_wait`+1 clocks (`cfg_wait` is 0 to 15).
- R3: Each second and later beat of a burst lasts `cfg_bwait`+1 clocks (`cfg_bwait` is 0 to 3).
- R4: `bs_n` is low for every cycle of the first beat and high in every later beat and while idle.
- R5: In the first beat, once the programmed wait has run out, each clock edge that samples `ext_wait` high adds one clock to the beat. `ext_wait` has no effect at any other time, and in particular none on later beats.
- R6: The first beat uses `req_addr`. Each later beat uses the previous address plus DW/8 (4 for 32-bit data). `bus_addr` takes a new value only on the falling clock edge, half a clock after the rising edge that starts the beat.
- R7: A read is a burst only when `req_burst`=1 and `req_beats`>1. Any other read (including `req_beats`=0 or 1) and every write is one beat with first-beat timing. A write drives `wr_n` low in place of `rd_n` and produces no `rdata_valid`.
- R8: For each read beat, `bus_din` is captured on the rising edge that ends the beat. In the clock after that edge, `rdata` holds the captured word and `rdata_valid` is 1 for exactly that clock.
- R9: On the edge that ends the last beat, `cs_n`, `rd_n`/`wr_n` and `bs_n` all go high together. `req_ready` stays low for one more clock and then goes high. A request is accepted only on an edge where `req_ready` is 1.
- R10: While `rst` is high, `cs_n`, `rd_n`, `wr_n` and `bs_n` are 1, `rdata_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Byte address of the first beat |
| req_beats | input | BCW | Number of beats of a burst read |
| req_write | input | 1 | 1 = write access |
| req_burst | input | 1 | 1 = burst read requested |
| cfg_wait | input | WW | Wait clocks of the first beat |
| cfg_bwait | input | BWW | Wait clocks of each later beat |
| ext_wait | input | 1 | External wait, active high, first beat only |
| bus_din | input | DW | Data from the ROM |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bs_n | output | 1 | Bus-start strobe, active low |
| bus_addr | output | AW | ROM address, launched on the falling edge |
| rdata | output | DW | Captured read word |
| rdata_valid | output | 1 | One-clock pulse marking a new `rdata` |

## Verification
The hardest case is showing that `ext_wait` matters in only one cycle window: the first beat's zero-count cycle and the cycles that follow while it stays high. The stimulus holds `ext_wait` high over windows placed relative to the accepting edge. One window straddles the end of the programmed wait. Another starts one clock after it and runs through every later beat. A write gets its own window. The reference model has to show the exact beat stretch in the first case and no change in the other. The falling-edge address launch is checked by sampling `bus_addr` both before and after the falling edge in every clock. The bench also holds `req_valid` high across several transactions to check the one-clock recovery gap.

// File: rtl/pgrom_pkg.sv
`timescale 1ns/1ps
package pgrom_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_NEXT  = 2'd2,
    PH_GAP   = 2'd3
  } ph_e;
endpackage

// File: rtl/pgrom_wait_ctr.sv
`timescale 1ns/1ps
// Loadable down counter that times the wait clocks of one beat.
module pgrom_wait_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_WAIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/pgrom_addr_gen.sv
`timescale 1ns/1ps
// Beat address pointer (rising edge) with a falling-edge launch register.
module pgrom_addr_gen #(
  parameter int AW   = 26,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  output logic [AW-1:0] bus_addr
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [AW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (start) ptr <= start_addr;
    else if (step)  ptr <= ptr + STEP_A;
  end

  // launch half a clock later so the ROM sees a settled address mid-cycle
  always_ff @(negedge clk) begin
    if (rst) bus_addr <= '0;
    else     bus_addr <= ptr;
  end

  AST_ADDR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (step && !start) |=> (ptr == $past(ptr) + STEP_A)); // R6
endmodule

// File: rtl/pgrom_seq.sv
`timescale 1ns/1ps
// Beat sequencer: strobes, burst bookkeeping and read capture.
module pgrom_seq
  import pgrom_pkg::*;
#(
  parameter int DW  = 32,
  parameter int BCW = 4,
  parameter int WW  = 4,
  parameter int BWW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [BCW-1:0] req_beats,
  input  logic           req_write,
  input  logic           req_burst,
  input  logic [WW-1:0]  cfg_wait,
  input  logic [BWW-1:0] cfg_bwait,
  input  logic           ext_wait,
  input  logic           cnt_zero,
  input  logic [DW-1:0]  bus_din,
  output logic           cnt_load,
  output logic [WW-1:0]  cnt_val,
  output logic           accept,
  output logic           step,
  output logic           cs_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           bs_n,
  output logic [DW-1:0]  rdata,
  output logic           rdata_valid,
  output logic           req_ready
);
  ph_e            ph;
  logic [BCW-1:0] rem;
  logic           is_wr;
  logic           beat_end;
  logic           is_burst;

  always_comb begin
    accept   = (ph == PH_IDLE) && req_ready && req_valid;
    beat_end = cnt_zero && (((ph == PH_FIRST) && !ext_wait) || (ph == PH_NEXT));
    step     = beat_end && (rem != '0);
    cnt_load = accept || step;
    cnt_val  = accept ? cfg_wait : WW'(cfg_bwait);
    is_burst = req_burst && !req_write && (req_beats > BCW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= PH_IDLE;
      rem         <= '0;
      is_wr       <= 1'b0;
      cs_n        <= 1'b1;
      rd_n        <= 1'b1;
      wr_n        <= 1'b1;
      bs_n        <= 1'b1;
      rdata       <= '0;
      rdata_valid <= 1'b0;
      req_ready   <= 1'b1;
    end else begin
      rdata_valid <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph        <= PH_FIRST;
            cs_n      <= 1'b0;
            rd_n      <= req_write;
            wr_n      <= !req_write;
            bs_n      <= 1'b0;
            req_ready <= 1'b0;
            is_wr     <= req_write;
            rem       <= is_burst ? req_beats - 1'b1 : '0;
          end
        end
        PH_FIRST, PH_NEXT: begin
          if (beat_end) begin
            bs_n <= 1'b1;
            if (!is_wr) begin
              rdata       <= bus_din;
              rdata_valid <= 1'b1;
            end
            if (step) begin
              rem <= rem - 1'b1;
              ph  <= PH_NEXT;
            end else begin
              ph   <= PH_GAP;
              cs_n <= 1'b1;
              rd_n <= 1'b1;
              wr_n <= 1'b1;
            end
          end
        end
        PH_GAP: begin
          ph        <= PH_IDLE;
          req_ready <= 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_BURST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_NEXT) |-> (!cs_n && !rd_n)); // R1
  AST_BS_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_NEXT) |-> bs_n); // R4
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rd_n && wr_n && bs_n && !req_ready)); // R9
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n); // R9
  AST_NO_VALID_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !rdata_valid); // R7
endmodule

// File: rtl/pgrom_rd_ctrl.sv
`timescale 1ns/1ps
// Top: page-mode ROM read sequencer.
module pgrom_rd_ctrl #(
  parameter int AW  = 26,
  parameter int DW  = 32,
  parameter int BCW = 4,
  parameter int WW  = 4,
  parameter int BWW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [BCW-1:0] req_beats,
  input  logic           req_write,
  input  logic           req_burst,
  input  logic [WW-1:0]  cfg_wait,
  input  logic [BWW-1:0] cfg_bwait,
  input  logic           ext_wait,
  input  logic [DW-1:0]  bus_din,
  output logic           cs_n,
  output logic           rd_n,
  output logic           wr_n,
  output logic           bs_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  rdata,
  output logic           rdata_valid
);
  localparam int BYTES = DW / 8;

  logic          cnt_load;
  logic [WW-1:0] cnt_val;
  logic          cnt_zero;
  logic          accept;
  logic          step;

  pgrom_wait_ctr #(.CW(WW)) u_wait (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  pgrom_addr_gen #(.AW(AW), .STEP(BYTES)) u_addr (
    .clk(clk), .rst(rst), .start(accept), .start_addr(req_addr),
    .step(step), .bus_addr(bus_addr)
  );

  pgrom_seq #(.DW(DW), .BCW(BCW), .WW(WW), .BWW(BWW)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_beats(req_beats),
    .req_write(req_write), .req_burst(req_burst), .cfg_wait(cfg_wait),
    .cfg_bwait(cfg_bwait), .ext_wait(ext_wait), .cnt_zero(cnt_zero),
    .bus_din(bus_din), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .accept(accept), .step(step), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .bs_n(bs_n), .rdata(rdata), .rdata_valid(rdata_valid), .req_ready(req_ready)
  );
endmodule

// File: tb/tb_pgrom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_pgrom_rd_ctrl;
  localparam int AW = 26, DW = 32, BCW = 4, WW = 4, BWW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst = 1'b1;
  logic           req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0, ext_wait = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [BCW-1:0] req_beats = '0;
  logic [WW-1:0]  cfg_wait = '0;
  logic [BWW-1:0] cfg_bwait = '0;
  logic [DW-1:0]  bus_din;
  logic           req_ready, cs_n, rd_n, wr_n, bs_n, rdata_valid;
  logic [AW-1:0]  bus_addr;
  logic [DW-1:0]  rdata;

  function automatic logic [DW-1:0] rom(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'hA5C3, a[17:2]};
  endfunction

  assign bus_din = rom(bus_addr);

  pgrom_rd_ctrl #(.AW(AW), .DW(DW), .BCW(BCW), .WW(WW), .BWW(BWW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_write(req_write),
    .req_burst(req_burst), .cfg_wait(cfg_wait), .cfg_bwait(cfg_bwait),
    .ext_wait(ext_wait), .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .bs_n(bs_n), .bus_addr(bus_addr), .rdata(rdata),
    .rdata_valid(rdata_valid)
  );

  int vectors = 0, fails = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 first beat, 2 later beat, 3 recovery
  int ph = 0, wc = 0, rem = 0;
  bit wflag = 0;
  logic e_cs = 1, e_rd = 1, e_wr = 1, e_bs = 1, e_valid = 0, e_ready = 1;
  logic [DW-1:0] e_rdata = '0;
  logic [AW-1:0] maddr = '0, maddr_prev = '0;

  task automatic end_beat();
    if (!wflag) begin e_valid = 1; e_rdata = rom(maddr); end
    e_bs = 1;
    if (rem > 0) begin
      rem--; ph = 2; wc = int'(cfg_bwait); maddr = maddr + AW'(DW/8);
    end else begin
      ph = 3; e_cs = 1; e_rd = 1; e_wr = 1;
    end
  endtask

  always @(posedge clk) begin
    maddr_prev = maddr;
    e_valid = 0;
    if (rst) begin
      ph = 0; e_cs = 1; e_rd = 1; e_wr = 1; e_bs = 1; e_ready = 1; maddr = '0;
    end else begin
      case (ph)
        0: if (req_valid && e_ready) begin
             ph = 1; e_cs = 0; e_rd = req_write; e_wr = !req_write; e_bs = 0; e_ready = 0;
             wc = int'(cfg_wait); wflag = req_write; maddr = req_addr;
             rem = (req_burst && !req_write && req_beats > 1) ? int'(req_beats) - 1 : 0;
           end
        1: if (wc > 0) wc--; else if (!ext_wait) end_beat();
        2: if (wc > 0) wc--; else end_beat();
        default: begin ph = 0; e_ready = 1; end
      endcase
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_en) begin
      chk("R1 cs_n", cs_n, e_cs);
      chk("R1 rd_n", rd_n, e_rd);
      chk("R7 wr_n", wr_n, e_wr);
      chk("R4 bs_n", bs_n, e_bs);
      chk("R8 rdata_valid", rdata_valid, e_valid);
      if (e_valid) chk("R8 rdata", rdata, e_rdata);
      chk("R9 req_ready", req_ready, e_ready);
      chk("R6 addr before falling edge", bus_addr, maddr_prev);
    end
    #4;
    if (cmp_en) chk("R6 addr after falling edge", bus_addr, maddr);
  end

  task automatic run_req(input logic [AW-1:0] a, input int beats, input bit wr,
                         input bit bu, input int w, input int bw,
                         input int es, input int ee, output int cyc);
    while (!req_ready) begin @(posedge clk); #1; end
    cfg_wait = WW'(w); cfg_bwait = BWW'(bw);
    req_addr = a; req_beats = BCW'(beats); req_write = wr; req_burst = bu;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cyc = 0;
    do begin
      ext_wait = (cyc >= es && cyc < ee);
      @(posedge clk); #1;
      cyc++;
    end while (!req_ready && cyc < 500);
    ext_wait = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL R9 watchdog: act=hung exp=idle");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #2;
    chk("R10 cs_n", cs_n, 1'b1);
    chk("R10 rd_n", rd_n, 1'b1);
    chk("R10 wr_n", wr_n, 1'b1);
    chk("R10 bs_n", bs_n, 1'b1);
    chk("R10 rdata_valid", rdata_valid, 1'b0);
    chk("R10 req_ready", req_ready, 1'b1);
    #(8 - 2 + 1);
    rst = 1'b0;
    cmp_en = 1'b1;
    @(posedge clk); #1;

    run_req(26'h0001000, 4, 0, 1, 2, 1, 99, 99, c);
    chk("R2 R3 burst4 length", c, 10);
    run_req(26'h0002040, 8, 0, 1, 0, 0, 99, 99, c);
    chk("R3 burst8 zero-wait length", c, 9);
    run_req(26'h3FFFFF0, 4, 0, 1, 15, 3, 99, 99, c);
    chk("R2 R3 max-wait length", c, 29);
    run_req(26'h0000100, 4, 0, 1, 1, 1, 0, 5, c);
    chk("R5 ext wait stretches first beat", c, 13);
    run_req(26'h0000200, 3, 0, 1, 0, 2, 1, 30, c);
    chk("R5 ext wait ignored on later beats", c, 8);
    run_req(26'h0000300, 4, 0, 0, 3, 1, 99, 99, c);
    chk("R7 single read without burst flag", c, 5);
    run_req(26'h0000400, 1, 0, 1, 1, 3, 99, 99, c);
    chk("R7 burst flag with one beat", c, 3);
    run_req(26'h0000500, 4, 1, 1, 2, 3, 2, 4, c);
    chk("R7 write is single with ext wait", c, 6);
    run_req(26'h0000600, 0, 0, 1, 0, 3, 99, 99, c);
    chk("R7 zero beat count read", c, 2);

    // back-to-back requests held on the request port
    cfg_wait = '0; cfg_bwait = '0;
    req_addr = 26'h0000800; req_beats = 4'd2; req_write = 0; req_burst = 1;
    req_valid = 1'b1;
    repeat (30) begin @(posedge clk); #1; end
    req_valid = 1'b0;
    repeat (10) begin @(posedge clk); #1; end
    chk("R9 idle after held requests", req_ready, 1'b1);

    cmp_en = 1'b0;
    @(posedge clk); #7;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule